// File: doc/BRIEF.md
# All-Pairs Single-Pass Maximum Finder

This block returns the largest of a group of unsigned words after one clock edge. It does not use a reduction tree. Every word is compared with every other word at the same time in a square grid of comparators. Each word carries a survival flag. The flag drops when some other word is strictly greater than it. The words that keep their flag all hold the maximum, so they may all drive the result at once without any arbitration. The logic depth does not grow with a chain of comparison stages.

A caller places all words on one wide bus and raises `start` for a cycle. On that clock edge the block registers three things: the maximum value, a bit mask of every position that holds the maximum, and a one-cycle `done` flag. With `start` low the outputs keep their last values, whatever happens on the input bus.

Top module: `allpairs_max`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `done` is 0, `max_out` is 0 and `winners` is 0.
- R2: When `start` is high at a rising edge, `max_out` holds the unsigned maximum of the N words from that edge on. Word k is `data_in[k*DATA_W +: DATA_W]`.
- R3: At the same edge, bit k of `winners` is set exactly when word k equals that maximum.
- R4: When several words share the maximum, each of them has its `winners` bit set and `max_out` still equals the shared value.
- R5: When all words are equal, every `winners` bit is set.
- R6: `done` is high in the cycle after each edge at which `start` was high, and low in every other cycle. Back-to-back starts give back-to-back `done` cycles, each with its own result.
- R7: With `start` low, changes on `data_in` leave `max_out` and `winners` unchanged.
- R8: Comparison is unsigned. A word with its top bit set is larger than any word with that bit clear.
- R9: Whenever `done` is high, at least one `winners` bit is set, and every surviving word agrees with the merged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample `data_in` and register the result |
| data_in | input | N_ELEM*DATA_W | Packed input words, word k at bits k*DATA_W upward |
| max_out | output | DATA_W | Registered maximum value |
| winners | output | N_ELEM | Registered mask of positions holding the maximum |
| done | output | 1 | One-cycle flag, result registered |

## Verification
The stimulus targets ties at the maximum and a fully uniform input. A design that let a flag fall on an equal value, including a word against itself, would clear winner bits or leave no survivor at all. Words that differ only in the top bit expose a signed compare, which would report 0x7F over 0x80. Changing the input bus with `start` low, and holding `start` high for two cycles, catches an output register that loads on every cycle or a `done` that stretches or merges pulses.

// File: rtl/maxfind_pkg.sv
package maxfind_pkg;
  localparam int unsigned CMP_W = 64;

  // Strict unsigned less-than on zero-extended operands.
  function automatic logic is_below(input logic [CMP_W-1:0] a,
                                    input logic [CMP_W-1:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/pair_cmp_matrix.sv
module pair_cmp_matrix
  import maxfind_pkg::*;
#(
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_ELEM*DATA_W-1:0] words,
  output logic [N_ELEM-1:0]        alive
);
  localparam int unsigned PAD_W = CMP_W - DATA_W;

  logic [N_ELEM-1:0] loses [N_ELEM];

  for (genvar i = 0; i < N_ELEM; i++) begin : g_row
    for (genvar j = 0; j < N_ELEM; j++) begin : g_col
      if (i == j) begin : g_diag
        assign loses[i][j] = 1'b0;
      end else begin : g_pair
        assign loses[i][j] = is_below({{PAD_W{1'b0}}, words[i*DATA_W +: DATA_W]},
                                      {{PAD_W{1'b0}}, words[j*DATA_W +: DATA_W]});
      end
    end
    assign alive[i] = ~|loses[i];
  end
endmodule

// File: rtl/survivor_merge.sv
module survivor_merge #(
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_ELEM*DATA_W-1:0] words,
  input  logic [N_ELEM-1:0]        alive,
  output logic [DATA_W-1:0]        merged,
  output logic [N_ELEM-1:0]        disagree
);
  logic [DATA_W-1:0] acc [N_ELEM+1];
  assign acc[0] = '0;

  for (genvar k = 0; k < N_ELEM; k++) begin : g_wr
    assign acc[k+1]    = acc[k] | (alive[k] ? words[k*DATA_W +: DATA_W] : '0);
    assign disagree[k] = alive[k] && (words[k*DATA_W +: DATA_W] != merged);
  end

  assign merged = acc[N_ELEM];
endmodule

// File: rtl/allpairs_max.sv
module allpairs_max #(
  parameter int unsigned N_ELEM = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N_ELEM*DATA_W-1:0] data_in,
  output logic [DATA_W-1:0]        max_out,
  output logic [N_ELEM-1:0]        winners,
  output logic                     done
);
  logic [N_ELEM-1:0] survivors;
  logic [N_ELEM-1:0] disagree;
  logic [DATA_W-1:0] merged;
  logic              any_survivor;
  logic              merge_conflict;

  pair_cmp_matrix #(.N_ELEM(N_ELEM), .DATA_W(DATA_W)) u_matrix (
    .words (data_in),
    .alive (survivors)
  );

  survivor_merge #(.N_ELEM(N_ELEM), .DATA_W(DATA_W)) u_merge (
    .words    (data_in),
    .alive    (survivors),
    .merged   (merged),
    .disagree (disagree)
  );

  assign any_survivor   = |survivors;
  assign merge_conflict = |disagree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_out <= '0;
      winners <= '0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        max_out <= merged;
        winners <= survivors;
      end
    end
  end

  // R9
  survivor_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> any_survivor);
  // R9
  no_merge_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !merge_conflict);
  // R9
  done_has_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (winners != '0));
  // R6
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(max_out) && $stable(winners)));
endmodule

// File: tb/test_allpairs_max.sv
module test_allpairs_max;
  localparam int N = 4;
  localparam int W = 8;
  localparam int NV = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] data_in = '0;
  logic [W-1:0]   max_out;
  logic [N-1:0]   winners;
  logic           done;

  int checks = 0;
  int errors = 0;

  // {data, expected max, expected mask}
  localparam logic [N*W+W+N-1:0] VEC [NV] = '{
    {32'h10203040, 8'h40, 4'b0001},   // R2 R3 distinct
    {32'h05FF01FF, 8'hFF, 4'b0101},   // R4 tie at maximum
    {32'h00000000, 8'h00, 4'b1111},   // R5 all zero
    {32'h7F800102, 8'h80, 4'b0100},   // R8 unsigned top bit
    {32'hAB12AB03, 8'hAB, 4'b1010},   // R4 tie at upper slots
    {32'hFFFFFFFF, 8'hFF, 4'b1111}    // R5 all ones
  };

  allpairs_max #(.N_ELEM(N), .DATA_W(W)) i_allpairs_max (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .max_out(max_out), .winners(winners), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [N*W-1:0] d, input logic [W-1:0] em, input logic [N-1:0] ew);
    @(negedge clk); data_in = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R6 done", {31'b0, done}, 32'd1);
    check("R2 max", {24'b0, max_out}, {24'b0, em});
    check("R3 mask", {28'b0, winners}, {28'b0, ew});
    @(negedge clk);
    check("R6 done low", {31'b0, done}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
      begin
        repeat (2) @(negedge clk);
        check("R1 max", {24'b0, max_out}, 32'd0);
        check("R1 mask", {28'b0, winners}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after release", {31'b0, done}, 32'd0);

        for (int v = 0; v < NV; v++)
          run_one(VEC[v][N*W+W+N-1 -: N*W], VEC[v][W+N-1 -: W], VEC[v][N-1:0]);

        // R7: input changes without start are ignored
        data_in = 32'h01020304;
        repeat (3) @(negedge clk);
        check("R7 max held", {24'b0, max_out}, 32'hFF);
        check("R7 mask held", {28'b0, winners}, 32'hF);

        // R6: back-to-back starts
        data_in = 32'h00000009; start = 1'b1;
        @(negedge clk);
        data_in = 32'h0C000000;
        check("R6 first done", {31'b0, done}, 32'd1);
        check("R2 first max", {24'b0, max_out}, 32'h09);
        check("R3 first mask", {28'b0, winners}, 32'h1);
        @(negedge clk); start = 1'b0;
        check("R6 second done", {31'b0, done}, 32'd1);
        check("R2 second max", {24'b0, max_out}, 32'h0C);
        check("R3 second mask", {28'b0, winners}, 32'h8);
        @(negedge clk);
        check("R6 idle", {31'b0, done}, 32'd0);

        // R8: single top-bit word wins
        run_one(32'h7F7F807F, 8'h80, 4'b0010);

        // R1: reset clears a held result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset max", {24'b0, max_out}, 32'd0);
        check("R1 reset mask", {28'b0, winners}, 32'd0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule